// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block keeps the 32-bit floating-point status word of an arithmetic unit. When an operation finishes, the unit presents a 5-bit set of raised IEEE exception flags. The recorder compares those flags with the trap-enable mask held in the status word and decides whether the operation must trap.

On a trap, the enabled flags are reduced to a single flag by a fixed priority. That flag becomes the current-exception field, the trap-type field is set to the IEEE-exception code, and the accrued field is left alone. Without a trap, every raised flag is copied into the current-exception field and ORed into the accrued field. A separate write port loads the whole word, for example to set the trap-enable mask. The new word and a one-cycle trap request are both registered.

Within each 5-bit field the flag order, from bit 4 down to bit 0, is: invalid, overflow, underflow, divide-by-zero, inexact. The fields sit at these positions in the word: trap-enable mask at bits 27:23, trap type at bits 16:14, accrued field at bits 9:5, current field at bits 4:0.

Top module: `fpx_status_recorder`

## Requirements
- R1: While `rst` is high at a clock edge, `status_q` becomes zero and `trap_req` becomes low.
- R2: A cycle with `wr_en` high and `upd_valid` low loads `wr_data` into `status_q` at the next edge. `trap_req` is low after that edge.
- R3: `trap_req` is high in the cycle after an accepted update if and only if `upd_flags` ANDed with the trap-enable mask (bits 27:23 of the word being updated) is nonzero. It stays high for one cycle per trapping update.
- R4: On an update with nonzero flags and no trap, bits 4:0 are replaced by `upd_flags` and bits 9:5 become their old value ORed with `upd_flags`. All other bits, including the trap-type bits 16:14, are kept.
- R5: On a trapping update, bits 4:0 hold exactly one flag: the highest-priority bit of `upd_flags` AND mask. Priority runs from bit 4 (invalid) down to bit 0 (inexact).
- R6: On a trapping update, bits 16:14 are set to 3'b001 and the accrued bits 9:5 keep their value. All bits outside fields 4:0 and 16:14 are kept.
- R7: An update whose `upd_flags` are zero leaves the word unchanged and does not raise `trap_req`.
- R8: While `upd_valid` is low, `upd_flags` has no effect on `status_q` or `trap_req`.
- R9: When `wr_en` and `upd_valid` are both high in the same cycle, the update is applied to `wr_data` rather than to the old word. This includes taking the trap-enable mask from `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the whole status word from `wr_data` |
| wr_data | input | 32 | Status word value to load |
| upd_valid | input | 1 | An operation has finished; `upd_flags` is valid |
| upd_flags | input | 5 | Raised exception flags (bit 4 invalid … bit 0 inexact) |
| status_q | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle request to deliver an IEEE exception trap |

## Verification
Two functions can fall in the same cycle: a software-style load of the word and an exception update. The bench provokes this by asserting `wr_en` together with `upd_valid`. It picks `wr_data` so that its trap-enable mask differs from the mask held in the register, so the trap decision shows which word was used as the base. Its reference model applies the update on top of the written word and compares both `status_q` and `trap_req` after every edge. Back-to-back trapping updates and multi-flag priority cases are also run against the same model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int REG_W    = 32;
    localparam int FLAG_W   = 5;
    localparam int EN_LSB   = 23;
    localparam int ACC_LSB  = 5;
    localparam int CUR_LSB  = 0;
    localparam int TT_LSB   = 14;
    localparam int TT_W     = 3;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    typedef logic [REG_W-1:0]  word_t;
    typedef logic [FLAG_W-1:0] flags_t;

    typedef enum logic [2:0] {
        FLG_INEXACT = 3'd0,
        FLG_DIVZ    = 3'd1,
        FLG_UNDER   = 3'd2,
        FLG_OVER    = 3'd3,
        FLG_INVALID = 3'd4
    } flag_idx_e;

    typedef struct packed {
        logic   any;
        logic   take_trap;
        flags_t cur_set;
    } decision_t;

    function automatic flags_t field_get(input word_t w, input int lsb);
        return w[lsb +: FLAG_W];
    endfunction

    function automatic word_t field_put(input word_t w, input int lsb, input flags_t f);
        word_t r;
        r = w;
        r[lsb +: FLAG_W] = f;
        return r;
    endfunction

endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
    parameter int W = fpx_pkg::FLAG_W
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);
    logic [W:0] above;

    assign above[W] = 1'b0;

    generate
        for (genvar i = W - 1; i >= 0; i--) begin : g_bit
            assign above[i] = above[i+1] | req[i];
            assign grant[i] = req[i] & ~above[i+1];
        end
    endgenerate
endmodule

// File: rtl/fpx_trap_decide.sv
module fpx_trap_decide
    import fpx_pkg::*;
(
    input  flags_t    flags,
    input  flags_t    en_mask,
    output decision_t dec
);
    flags_t masked;
    flags_t single;

    assign masked = flags & en_mask;

    fpx_prio_pick #(.W(FLAG_W)) u_pick (
        .req   (masked),
        .grant (single)
    );

    always_comb begin
        dec.any       = |flags;
        dec.take_trap = |masked;
        dec.cur_set   = dec.take_trap ? single : flags;
    end
endmodule

// File: rtl/fpx_field_merge.sv
module fpx_field_merge
    import fpx_pkg::*;
(
    input  word_t     base,
    input  flags_t    flags,
    input  decision_t dec,
    output word_t     next_w
);
    always_comb begin
        next_w = base;
        if (dec.any) begin
            next_w = field_put(next_w, CUR_LSB, dec.cur_set);
            if (dec.take_trap) begin
                next_w[TT_LSB +: TT_W] = TT_IEEE;
            end else begin
                next_w = field_put(next_w, ACC_LSB, field_get(base, ACC_LSB) | flags);
            end
        end
    end
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              upd_valid,
    input  logic [FLAG_W-1:0] upd_flags,
    output logic [REG_W-1:0]  status_q,
    output logic              trap_req
);
    word_t     base;
    word_t     merged;
    decision_t dec;

    assign base = wr_en ? wr_data : status_q;

    fpx_trap_decide u_decide (
        .flags   (upd_flags),
        .en_mask (field_get(base, EN_LSB)),
        .dec     (dec)
    );

    fpx_field_merge u_merge (
        .base   (base),
        .flags  (upd_flags),
        .dec    (dec),
        .next_w (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            trap_req <= 1'b0;
        end else begin
            trap_req <= upd_valid & dec.take_trap;
            if (upd_valid) begin
                status_q <= merged;
            end else if (wr_en) begin
                status_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fpx_status_recorder_chk.sv
module fpx_status_recorder_chk
    import fpx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              upd_valid,
    input logic [FLAG_W-1:0] upd_flags,
    input logic [REG_W-1:0]  status_q,
    input logic              trap_req
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_TRAP_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        past_ok && trap_req |-> $past(upd_valid) && ($past(upd_flags) != '0)); // R3

    AST_TRAP_SINGLE_CURRENT: assert property (@(posedge clk) disable iff (rst)
        past_ok && trap_req |-> $countones(status_q[CUR_LSB +: FLAG_W]) == 1); // R5

    AST_TRAP_TYPE_CODE: assert property (@(posedge clk) disable iff (rst)
        past_ok && trap_req |-> status_q[TT_LSB +: TT_W] == TT_IEEE); // R6

    AST_TRAP_KEEPS_ACCRUED: assert property (@(posedge clk) disable iff (rst)
        past_ok && trap_req && !$past(wr_en) |->
            status_q[ACC_LSB +: FLAG_W] == $past(status_q[ACC_LSB +: FLAG_W])); // R6

    AST_ACCRUED_ONLY_GROWS: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(wr_en) |->
            (status_q[ACC_LSB +: FLAG_W] & $past(status_q[ACC_LSB +: FLAG_W]))
                == $past(status_q[ACC_LSB +: FLAG_W])); // R4

    AST_ZERO_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(upd_valid) && ($past(upd_flags) == '0) && !$past(wr_en) |->
            $stable(status_q) && !trap_req); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(upd_valid) && !$past(wr_en) |->
            $stable(status_q) && !trap_req); // R8
endmodule

bind fpx_status_recorder fpx_status_recorder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .upd_valid (upd_valid),
    .upd_flags (upd_flags),
    .status_q  (status_q),
    .trap_req  (trap_req)
);

// File: tb/sim_fpx_status_recorder.sv
module sim_fpx_status_recorder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        upd_valid = 1'b0;
    logic [4:0]  upd_flags = '0;
    logic [31:0] status_q;
    logic        trap_req;

    int n_vec  = 0;
    int n_fail = 0;

    logic [31:0] ref_w = '0;
    logic        ref_t = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpx_status_recorder u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .upd_valid(upd_valid), .upd_flags(upd_flags),
        .status_q(status_q), .trap_req(trap_req)
    );

    // behavioural reference: one clock edge of the status word
    task automatic model_edge();
        logic [31:0] w;
        logic [4:0]  m;
        logic [4:0]  pick;
        logic        found;
        w = wr_en ? wr_data : ref_w;
        ref_t = 1'b0;
        if (upd_valid) begin
            if (upd_flags != 0) begin
                m = upd_flags & w[27:23];
                if (m != 0) begin
                    pick = 0;
                    found = 1'b0;
                    for (int i = 4; i >= 0; i--) begin
                        if (!found && m[i]) begin
                            pick[i] = 1'b1;
                            found = 1'b1;
                        end
                    end
                    w[4:0]   = pick;
                    w[16:14] = 3'b001;
                    ref_t    = 1'b1;
                end else begin
                    w[4:0] = upd_flags;
                    w[9:5] = w[9:5] | upd_flags;
                end
            end
            ref_w = w;
        end else if (wr_en) begin
            ref_w = wr_data;
        end
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (status_q !== ref_w || trap_req !== ref_t) begin
            n_fail++;
            $display("FAIL %s: status=%08h trap=%0b expected status=%08h trap=%0b",
                     tag, status_q, trap_req, ref_w, ref_t);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] wd,
                        input logic v, input logic [4:0] f, input string tag);
        wr_en = we; wr_data = wd; upd_valid = v; upd_flags = f;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        wr_en = 1'b0; upd_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_w = '0; ref_t = 1'b0;
        compare("R1 reset state");

        // R2: plain load, mask enables overflow and div-by-zero only
        step(1, 32'h0500_0000 | (32'b01010 << 23), 0, 5'b0, "R2 load word");
        step(1, 32'h0000_0000 | (32'b01010 << 23), 0, 5'b0, "R2 load word again");

        // R4: no trap, flags accrue
        step(0, 0, 1, 5'b00001, "R4 inexact accrues");
        step(0, 0, 1, 5'b00100, "R4 underflow accrues");
        step(0, 0, 1, 5'b10101, "R4 disabled flags do not trap");

        // R7 / R8
        step(0, 0, 1, 5'b00000, "R7 zero flags hold");
        step(0, 0, 0, 5'b11111, "R8 flags without valid ignored");

        // R3 / R5 / R6: trapping with priority
        step(0, 0, 1, 5'b01011, "R5 overflow beats div-by-zero");
        step(0, 0, 1, 5'b00010, "R6 div-by-zero trap keeps accrued");
        step(1, (32'b11111 << 23) | 32'h0000_03e0, 0, 5'b0, "R2 enable all");
        step(0, 0, 1, 5'b11111, "R5 invalid wins over all");
        step(0, 0, 1, 5'b00110, "R3 back-to-back trap");
        step(0, 0, 1, 5'b00001, "R3 inexact-only trap");
        step(0, 0, 0, 5'b0, "R3 trap is one cycle");

        // R9: write and update together, mask from written word
        step(1, 32'h0000_4000, 1, 5'b11000, "R9 written mask zero gives no trap");
        step(1, (32'b00100 << 23), 1, 5'b00111, "R9 written mask gives trap");

        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 4) == 0, $urandom, ($urandom % 3) != 0,
                 5'($urandom), "R4 R5 R9 random mix");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule